// File: doc/BRIEF.md
# Two-Level I/O Translation Cache

This block keeps recent I/O page-walk results close to an IOMMU so that repeated DMA accesses from the same device to the same page skip the table walk. A request names a requester by device ID and carries a 64-bit I/O virtual address. A directly indexed context table turns the device ID into a 16-bit domain. A valid bit in each context entry separates an assigned domain from an unassigned one, because every domain number, zero included, is legal. The domain and the page number of the address then form a 64-bit tag. A fully associative array of translation entries is searched for that tag. A hit returns the stored physical address, access permissions and page-size shift.

The page walker writes results through the fill port and names the domain directly. Software-facing logic programs the context table through its own write port. A single flush input discards every cached translation. Until the array is full, new translations take free slots in ascending index order. After that, each new translation replaces the entry that has gone longest without being filled or hit.

Top module: `iotc_cache`

## Requirements
- R1: After reset every context entry is unassigned and no translation is cached. Any lookup then responds with the domain-miss flag set and the hit flag clear.
- R2: A lookup whose context entry is unassigned responds with domain-miss 1 and hit 0. A lookup whose entry is assigned responds with domain-miss 0, including when the assigned domain is 0.
- R3: The tag is {8'b0, domain[15:0], iova[51:12]}. Lookups that differ only in address bits 11:0 or 63:52 hit the same entry. A different bit 12 or a different domain misses.
- R4: A lookup presented in one cycle responds in the next cycle with the response-valid flag set. On a hit the response carries the stored physical address, permissions and shift, and the slot index of the entry. On a miss those fields are 0.
- R5: While fewer than ENTRIES slots hold translations, a fill with a new tag is written into the lowest free slot. The slot index equals the number of entries cached before the fill.
- R6: When all slots are in use, a fill with a new tag replaces the least recently used entry in that entry's slot. The evicted tag then misses.
- R7: A lookup hit makes the matching entry the most recently used. A newly filled entry is also the most recently used.
- R8: A fill whose tag is already cached overwrites that entry in place. It does not take a new slot.
- R9: The flush input discards every cached translation in one cycle and leaves the context table unchanged. The next new fill goes to slot 0.
- R10: A flush in the same cycle as a fill drops the fill. A lookup in the same cycle as a fill or flush sees the cache as it was before that cycle. A lookup hit refreshes recency only in a cycle with neither fill nor flush.
- R11: A lookup in the same cycle as a context-table write to its device uses the previous context entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request strobe |
| lkDevId | input | DEV_W | Requesting device ID (default 8) |
| lkIova | input | 64 | I/O virtual address of the lookup |
| fillValid | input | 1 | Fill strobe from the page walker |
| fillDomId | input | 16 | Domain of the filled translation |
| fillIova | input | 64 | I/O virtual address that was walked |
| fillPhys | input | 64 | Translated physical address |
| fillPerm | input | 3 | Access permission bits |
| fillShift | input | 6 | Page-size offset shift |
| dtWrEn | input | 1 | Context-table write strobe |
| dtWrDevId | input | DEV_W | Device ID to program |
| dtWrDomId | input | 16 | Domain to assign |
| dtWrValid | input | 1 | 1 assigns the domain, 0 unassigns the device |
| invAll | input | 1 | Flush every cached translation |
| rspValid | output | 1 | Response for the previous cycle's lookup |
| rspDomMiss | output | 1 | Device had no assigned domain |
| rspHit | output | 1 | Translation found |
| rspSlot | output | 6 | Slot index of the hit entry |
| rspPhys | output | 64 | Translated physical address |
| rspPerm | output | 3 | Permission bits |
| rspShift | output | 6 | Page-size shift |

## Verification
The assertions assume that lookup, fill, context-write and flush strobes are never X once reset is released. They also assume that the walker never fills while reset is active. The occupancy checks rely on fills being the only way to add entries and on the absence of any single-entry invalidation, so cached entries always form a prefix of the slots. The stimulus drives every input to a defined value in every cycle after reset. It draws device IDs, domains and page numbers from small pools so that tags collide, the array fills up and evictions happen. Flushes are rare enough that the full state is reached between them.

// File: rtl/iotc_pkg.sv
package iotc_pkg;
  localparam int DOM_W   = 16;
  localparam int VA_W    = 64;
  localparam int PA_W    = 64;
  localparam int PERM_W  = 3;
  localparam int SHIFT_W = 6;
  localparam int KEY_W   = 64;
  localparam int PAGE_SH = 12;
  localparam int VA_TOP  = 51;
  localparam int DOM_POS = 40;
  localparam int KEY_PAD = KEY_W - DOM_POS - DOM_W;

  typedef struct packed {
    logic [PA_W-1:0]    phys;
    logic [PERM_W-1:0]  perm;
    logic [SHIFT_W-1:0] shift;
  } walk_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic fillSame;
    logic fillFree;
    logic fillEvict;
    logic touch;
    logic dtWr;
  } ctrl_t;

  function automatic logic [KEY_W-1:0] makeKey(input logic [DOM_W-1:0] dom,
                                                input logic [VA_W-1:0] va);
    return {{KEY_PAD{1'b0}}, dom, va[VA_TOP:PAGE_SH]};
  endfunction
endpackage

// File: rtl/iotc_ctrl.sv
module iotc_ctrl
  import iotc_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             invAll,
  input  logic             fillValid,
  input  logic             fillMatch,
  input  logic             lkValid,
  input  logic             lkHit,
  input  logic             dtWrEn,
  output ctrl_t            strobes,
  output logic [CNT_W-1:0] occCount
);
  logic full;
  logic fillAny;

  assign full    = (occCount == CNT_W'(ENTRIES));
  assign fillAny = fillValid && !invAll;

  always_comb begin
    strobes           = '0;
    strobes.clearAll  = invAll;
    strobes.fillSame  = fillAny && fillMatch;
    strobes.fillFree  = fillAny && !fillMatch && !full;
    strobes.fillEvict = fillAny && !fillMatch && full;
    strobes.touch     = lkValid && lkHit && !invAll && !fillValid;
    strobes.dtWr      = dtWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occCount <= '0;
    end else if (strobes.clearAll) begin
      occCount <= '0;
    end else if (strobes.fillFree) begin
      occCount <= occCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/iotc_datapath.sv
module iotc_datapath
  import iotc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DEV_W   = 8,
  localparam int RANK_W = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int DEVS   = 1 << DEV_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              strobes,
  input  logic [CNT_W-1:0]   occCount,
  input  logic               lkValid,
  input  logic [DEV_W-1:0]   lkDevId,
  input  logic [VA_W-1:0]    lkIova,
  input  logic [DOM_W-1:0]   fillDomId,
  input  logic [VA_W-1:0]    fillIova,
  input  walk_t              fillWalk,
  input  logic [DEV_W-1:0]   dtWrDevId,
  input  logic [DOM_W-1:0]   dtWrDomId,
  input  logic               dtWrValid,
  output logic               lkHitNow,
  output logic               fillMatchNow,
  output logic [ENTRIES-1:0] entryValid,
  output logic               rspValid,
  output logic               rspDomMiss,
  output logic               rspHit,
  output logic [RANK_W-1:0]  rspSlot,
  output walk_t              rspWalk
);
  // First level: device -> domain
  logic [DEVS-1:0]  dtVld;
  logic [DOM_W-1:0] dtDom [DEVS];

  // Second level: tag array
  logic [KEY_W-1:0]  keyArr  [ENTRIES];
  walk_t             walkArr [ENTRIES];
  logic [RANK_W-1:0] rank    [ENTRIES];
  logic [ENTRIES-1:0] vld;

  logic [ENTRIES-1:0] lkMatchVec, fillMatchVec, lruVec;
  logic [KEY_W-1:0]   lkKey, fillKey;
  logic               lkDomOk;
  logic [RANK_W-1:0]  lkIdx, fillIdx, lruIdx, updSlot, refRank;
  logic               updEn, fillAny;

  function automatic logic [RANK_W-1:0] encIdx(input logic [ENTRIES-1:0] v);
    logic [RANK_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v[i]) r = r | RANK_W'(i);
    end
    return r;
  endfunction

  assign lkDomOk = dtVld[lkDevId];
  assign lkKey   = makeKey(dtDom[lkDevId], lkIova);
  assign fillKey = makeKey(fillDomId, fillIova);

  for (genvar g = 0; g < ENTRIES; g++) begin : gCam
    assign lkMatchVec[g]   = vld[g] && (keyArr[g] == lkKey);
    assign fillMatchVec[g] = vld[g] && (keyArr[g] == fillKey);
    assign lruVec[g]       = vld[g] && (rank[g] == RANK_W'(ENTRIES - 1));
  end

  assign lkIdx        = encIdx(lkMatchVec);
  assign fillIdx      = encIdx(fillMatchVec);
  assign lruIdx       = encIdx(lruVec);
  assign lkHitNow     = lkDomOk && (|lkMatchVec);
  assign fillMatchNow = |fillMatchVec;
  assign entryValid   = vld;

  assign fillAny = strobes.fillSame || strobes.fillFree || strobes.fillEvict;
  assign updEn   = fillAny || strobes.touch;

  always_comb begin
    if (strobes.fillSame)       updSlot = fillIdx;
    else if (strobes.fillFree)  updSlot = RANK_W'(occCount);
    else if (strobes.fillEvict) updSlot = lruIdx;
    else                        updSlot = lkIdx;
    refRank = strobes.fillFree ? RANK_W'(occCount) : rank[updSlot];
  end

  // Context table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dtVld <= '0;
    end else if (strobes.dtWr) begin
      dtVld[dtWrDevId] <= dtWrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.dtWr) dtDom[dtWrDevId] <= dtWrDomId;
  end

  // Valid bits and age ranks (0 = most recent)
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) rank[i] <= '0;
    end else if (updEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (RANK_W'(i) == updSlot) rank[i] <= '0;
        else if (vld[i] && (rank[i] < refRank)) rank[i] <= rank[i] + RANK_W'(1);
      end
      if (fillAny) vld[updSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillAny) begin
      keyArr[updSlot]  <= fillKey;
      walkArr[updSlot] <= fillWalk;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspDomMiss <= 1'b0;
      rspHit     <= 1'b0;
      rspSlot    <= '0;
      rspWalk    <= '0;
    end else begin
      rspValid   <= lkValid;
      rspDomMiss <= lkValid && !lkDomOk;
      rspHit     <= lkValid && lkHitNow;
      rspSlot    <= (lkValid && lkHitNow) ? lkIdx : '0;
      rspWalk    <= (lkValid && lkHitNow) ? walkArr[lkIdx] : '0;
    end
  end
endmodule

// File: rtl/iotc_cache.sv
module iotc_cache
  import iotc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DEV_W   = 8,
  localparam int RANK_W = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lkValid,
  input  logic [DEV_W-1:0]    lkDevId,
  input  logic [VA_W-1:0]     lkIova,
  input  logic                fillValid,
  input  logic [DOM_W-1:0]    fillDomId,
  input  logic [VA_W-1:0]     fillIova,
  input  logic [PA_W-1:0]     fillPhys,
  input  logic [PERM_W-1:0]   fillPerm,
  input  logic [SHIFT_W-1:0]  fillShift,
  input  logic                dtWrEn,
  input  logic [DEV_W-1:0]    dtWrDevId,
  input  logic [DOM_W-1:0]    dtWrDomId,
  input  logic                dtWrValid,
  input  logic                invAll,
  output logic                rspValid,
  output logic                rspDomMiss,
  output logic                rspHit,
  output logic [RANK_W-1:0]   rspSlot,
  output logic [PA_W-1:0]     rspPhys,
  output logic [PERM_W-1:0]   rspPerm,
  output logic [SHIFT_W-1:0]  rspShift
);
  ctrl_t              strobes;
  logic [CNT_W-1:0]   occCount;
  logic               lkHitNow, fillMatchNow;
  logic [ENTRIES-1:0] entryValid;
  walk_t              fillWalk, rspWalk;

  assign fillWalk = '{phys: fillPhys, perm: fillPerm, shift: fillShift};
  assign rspPhys  = rspWalk.phys;
  assign rspPerm  = rspWalk.perm;
  assign rspShift = rspWalk.shift;

  iotc_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .invAll(invAll), .fillValid(fillValid),
    .fillMatch(fillMatchNow), .lkValid(lkValid), .lkHit(lkHitNow),
    .dtWrEn(dtWrEn), .strobes(strobes), .occCount(occCount)
  );

  iotc_datapath #(.ENTRIES(ENTRIES), .DEV_W(DEV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .occCount(occCount),
    .lkValid(lkValid), .lkDevId(lkDevId), .lkIova(lkIova),
    .fillDomId(fillDomId), .fillIova(fillIova), .fillWalk(fillWalk),
    .dtWrDevId(dtWrDevId), .dtWrDomId(dtWrDomId), .dtWrValid(dtWrValid),
    .lkHitNow(lkHitNow), .fillMatchNow(fillMatchNow), .entryValid(entryValid),
    .rspValid(rspValid), .rspDomMiss(rspDomMiss), .rspHit(rspHit),
    .rspSlot(rspSlot), .rspWalk(rspWalk)
  );
endmodule

// File: rtl/iotc_checker.sv
module iotc_checker #(
  parameter int ENTRIES = 64,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               invAll,
  input logic               fillFree,
  input logic               rspValid,
  input logic               rspDomMiss,
  input logic               rspHit,
  input logic [CNT_W-1:0]   occCount,
  input logic [ENTRIES-1:0] entryValid
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);                                              // R4
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!rspValid && !rspHit && !rspDomMiss));                // R4
  AST_DOMMISS_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspDomMiss |-> !rspHit);                                            // R2
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occCount <= CNT_W'(ENTRIES));                                       // R5
  AST_OCC_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $countones(entryValid) == int'(occCount));                          // R5
  AST_FREE_FILL_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    fillFree |=> (occCount == $past(occCount) + CNT_W'(1)));           // R5
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (occCount == CNT_W'(ENTRIES) && !invAll) |=> (occCount == CNT_W'(ENTRIES))); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> (occCount == '0 && entryValid == '0));                  // R9
endmodule

bind iotc_cache iotc_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .invAll(invAll),
  .fillFree(strobes.fillFree), .rspValid(rspValid), .rspDomMiss(rspDomMiss),
  .rspHit(rspHit), .occCount(occCount), .entryValid(entryValid)
);

// File: tb/iotc_cache_bench.sv
module iotc_cache_bench;
  localparam int N = 64;
  localparam int DW = 8;

  logic clk = 0, rstN = 0;
  logic lkValid = 0, fillValid = 0, dtWrEn = 0, dtWrValid = 0, invAll = 0;
  logic [DW-1:0] lkDevId = 0, dtWrDevId = 0;
  logic [63:0] lkIova = 0, fillIova = 0, fillPhys = 0;
  logic [15:0] fillDomId = 0, dtWrDomId = 0;
  logic [2:0] fillPerm = 0;
  logic [5:0] fillShift = 0;
  logic rspValid, rspDomMiss, rspHit;
  logic [5:0] rspSlot, rspShift;
  logic [63:0] rspPhys;
  logic [2:0] rspPerm;

  int errors = 0, checks = 0;

  iotc_cache #(.ENTRIES(N), .DEV_W(DW)) u_iotc_cache (.*);

  always #10 clk = ~clk;

  // Reference model
  bit          mVld [N];
  logic [63:0] mKey [N], mPa [N];
  logic [2:0]  mPerm [N];
  logic [5:0]  mSh [N];
  int          mStamp [N];
  int          stampCtr = 0, occ = 0;
  bit          dtV [1<<DW];
  logic [15:0] dtD [1<<DW];

  function automatic logic [63:0] tagOf(logic [15:0] d, logic [63:0] va);
    return {8'h00, d, va[51:12]};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(bit doLk, logic [DW-1:0] dev, logic [63:0] va,
                      bit doFill, logic [15:0] fDom, logic [63:0] fVa, logic [63:0] fPa,
                      logic [2:0] fPerm, logic [5:0] fSh,
                      bit doDt, logic [DW-1:0] dDev, logic [15:0] dDom, bit dVld,
                      bit doInv, string tag);
    bit eDm, eHit; int eSlot, slot; logic [63:0] k;
    lkValid = doLk; lkDevId = dev; lkIova = va;
    fillValid = doFill; fillDomId = fDom; fillIova = fVa; fillPhys = fPa;
    fillPerm = fPerm; fillShift = fSh;
    dtWrEn = doDt; dtWrDevId = dDev; dtWrDomId = dDom; dtWrValid = dVld;
    invAll = doInv;
    eDm = 0; eHit = 0; eSlot = 0;
    if (doLk) begin
      if (!dtV[dev]) eDm = 1;
      else begin
        k = tagOf(dtD[dev], va);
        for (int i = 0; i < N; i++) if (mVld[i] && mKey[i] == k) begin eHit = 1; eSlot = i; end
      end
    end
    @(negedge clk);
    chk(tag, "rspValid", 64'(rspValid), 64'(doLk));
    if (doLk) begin
      chk(tag, "domMiss", 64'(rspDomMiss), 64'(eDm));
      chk(tag, "hit", 64'(rspHit), 64'(eHit));
      chk(tag, "slot", 64'(rspSlot), eHit ? 64'(eSlot) : 64'd0);
      chk(tag, "phys", rspPhys, eHit ? mPa[eSlot] : 64'd0);
      chk(tag, "perm", 64'(rspPerm), eHit ? 64'(mPerm[eSlot]) : 64'd0);
      chk(tag, "shift", 64'(rspShift), eHit ? 64'(mSh[eSlot]) : 64'd0);
    end
    if (doInv) begin
      for (int i = 0; i < N; i++) mVld[i] = 0;
      occ = 0;
    end else if (doFill) begin
      k = tagOf(fDom, fVa); slot = -1;
      for (int i = 0; i < N; i++) if (mVld[i] && mKey[i] == k) slot = i;
      if (slot < 0) begin
        if (occ < N) begin slot = occ; occ++; end
        else begin
          slot = 0;
          for (int i = 1; i < N; i++) if (mStamp[i] < mStamp[slot]) slot = i;
        end
      end
      mVld[slot] = 1; mKey[slot] = k; mPa[slot] = fPa; mPerm[slot] = fPerm; mSh[slot] = fSh;
      mStamp[slot] = ++stampCtr;
    end else if (eHit) begin
      mStamp[eSlot] = ++stampCtr;
    end
    if (doDt) begin dtV[dDev] = dVld; dtD[dDev] = dDom; end
  endtask

  task automatic look(logic [DW-1:0] dev, logic [63:0] va, string tag);
    tick(1, dev, va, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic fill(logic [15:0] d, logic [63:0] va, logic [63:0] pa, string tag);
    tick(0, 0, 0, 1, d, va, pa, pa[2:0], pa[17:12], 0, 0, 0, 0, 0, tag);
  endtask
  task automatic dtw(logic [DW-1:0] dev, logic [15:0] d, bit v, string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, dev, d, v, 0, tag);
  endtask
  task automatic flush(string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  function automatic logic [63:0] pg(int p);
    return 64'h0000_0040_0000_0000 + (64'(p) << 12);
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    look(3, pg(1), "R1");
    // R2: domain 0 is legal
    dtw(3, 16'h0000, 1, "R2");
    look(3, pg(1), "R2");
    // R4: fill and hit
    fill(16'h0000, pg(1), 64'h0000_1234_5678_9000, "R4");
    look(3, pg(1), "R4");
    // R3: key composition
    look(3, pg(1) | 64'hfff, "R3");
    look(3, pg(1) | 64'hABC0_0000_0000_0000, "R3");
    look(3, pg(1) ^ 64'h1000, "R3");
    dtw(5, 16'h0001, 1, "R3");
    look(5, pg(1), "R3");
    // R11: same-cycle context write and lookup
    tick(1, 3, pg(1), 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0, "R11");
    look(3, pg(1), "R11");
    dtw(3, 16'h0000, 1, "R11");
    // R9: flush leaves context table, next fill to slot 0
    flush("R9");
    look(3, pg(1), "R9");
    fill(16'h0000, pg(7), 64'h0000_0000_0abc_d000, "R9");
    look(3, pg(7), "R9");
    flush("R9");
    // R5: fill all slots in order
    for (int p = 0; p < N; p++) fill(16'h0000, pg(p), 64'h1000_0000 + (64'(p) << 12) + 64'(p % 8), "R5");
    for (int p = 0; p < N; p++) look(3, pg(p), "R5");
    // R8: refill of cached tag stays in place
    fill(16'h0000, pg(5), 64'h0000_00ff_0000_0007, "R8");
    look(3, pg(5), "R8");
    // R7: touch entry 0, then R6 eviction goes to next-oldest
    for (int p = 0; p < N; p++) if (p != 1) look(3, pg(p), "R7");
    fill(16'h0000, pg(200), 64'h0000_0000_7777_7000, "R6");
    look(3, pg(1), "R6");
    look(3, pg(200), "R6");
    fill(16'h0000, pg(201), 64'h0000_0000_8888_8000, "R6");
    look(3, pg(201), "R7");
    // R10: flush beats fill; lookup sees pre-state
    tick(0, 0, 0, 1, 16'h0000, pg(300), 64'h5000, 0, 0, 0, 0, 0, 0, 1, "R10");
    look(3, pg(300), "R10");
    tick(1, 3, pg(301), 1, 16'h0000, pg(301), 64'h6000, 1, 0, 0, 0, 0, 0, 0, "R10");
    look(3, pg(301), "R10");
    tick(1, 3, pg(301), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    look(3, pg(301), "R10");
    // Random phase
    for (int d = 0; d < 8; d++) dtw(DW'(d), 16'(d % 4), d != 6, "R2");
    for (int c = 0; c < 6000; c++) begin
      bit dl, df, dd, di;
      dl = $urandom_range(0, 99) < 60;
      df = $urandom_range(0, 99) < 35;
      dd = $urandom_range(0, 99) < 3;
      di = $urandom_range(0, 999) < 3;
      tick(dl, DW'($urandom_range(0, 7)), pg($urandom_range(0, 90)) | 64'($urandom_range(0, 4095)),
           df, 16'($urandom_range(0, 3)), pg($urandom_range(0, 90)),
           {32'h0, $urandom}, 3'($urandom), 6'($urandom),
           dd, DW'($urandom_range(0, 7)), 16'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
           di, "R4");
    end
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    summary();
  end
endmodule